// File: doc/BRIEF.md
# Vectored Interrupt Poll and Acknowledge Controller

This block is the interrupt front end of a small 8-bit processor core. It keeps one request flag for each of seven sources: two external pins, two timer overflows and three peripheral requests (UART, I2C and ADC). It freezes a snapshot of those flags at every machine-cycle strobe. At the following strobe it judges that snapshot against a global enable, a per-source enable and a blocking condition from the CPU. When a source wins, the block raises a one-cycle acknowledge. With it comes a 16-bit vector address, which the sequencer turns into a forced long subroutine call. That call saves only the program counter.

Acknowledge also sets an in-service flip-flop. While it is set, no further source is accepted. A return strobe from the sequencer clears it. The block keeps no memory of requests that were blocked: every poll looks only at the latest snapshot. Hardware clears a timer flag, or an external flag in edge mode, when that source is acknowledged. An external flag in level mode simply follows its pin. The peripheral requests are passed through untouched, so software must clear them at their source.

Top module: `irq_poll_ctrl`

## Requirements
- R1: After reset, `ack_o` is 0, all bits of `flags_o` are 0, the enable register is 0 and the in-service flip-flop is clear.
- R2: Enable register bit i (written through `en_wr`/`en_wdata`) enables source i for i = 0..6, and bit 7 is the global enable. With bit 7 at 0, or with a source's own bit at 0, that source is never acknowledged and its flag is left as it was.
- R3: A poll takes place on every clock where `cyc_stb` is 1. It judges the snapshot taken at the previous strobe, and `ack_o` rises in the clock cycle that follows the polling strobe.
- R4: Source index: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 UART, 5 I2C, 6 ADC. When several enabled sources are pending in one poll, the lowest index wins.
- R5: `ack_o` is high for exactly one cycle. During that cycle `src_o` holds the winning index and `vec_o` = 0x0003 + 8 × index (for example 0x000B for timer 0 and 0x0013 for external 1).
- R6: Acknowledge sets the in-service flip-flop. No further acknowledge is issued until a `reti_stb` pulse clears it.
- R7: No acknowledge is issued from a poll while `blocked` is 1. A level request that goes away before the block lifts is never serviced, because no pending state is kept.
- R8: On acknowledge, hardware clears the winning timer flag, and the winning external flag only when that input is in edge mode (`ext_edge` bit = 1). A level-mode external flag follows its pin and is not cleared.
- R9: The UART, I2C and ADC flags (`flags_o[6:4]`) follow `per_req` one clock late and are never cleared by acknowledge, so a held request is serviced again after each return.
- R10: In edge mode, a rising edge on `ext_pin[j]` sets flag index 2j one clock later, and the flag stays set after the pin falls until it is acknowledged.
- R11: A one-cycle pulse on `tmr_ovf[j]` sets flag index 2j+1 one clock later, and the flag stays set until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_stb | input | 1 | Machine-cycle strobe: take a snapshot and poll |
| ext_pin | input | 2 | External request pins, active high |
| ext_edge | input | 2 | Per pin: 1 = edge-triggered, 0 = level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| per_req | input | 3 | UART, I2C and ADC request levels |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data |
| blocked | input | 1 | CPU blocking condition for this poll |
| reti_stb | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | One-cycle acknowledge |
| src_o | output | 3 | Winning source index |
| vec_o | output | 16 | Vector address of the winning source |
| flags_o | output | 7 | Current request flags, indexed by source |

## Verification
Two timers that overflow together while a UART request is held separate the priority order from the arrival order. The same test shows that a held peripheral request is serviced again after each return, while a timer flag is not. A level request on external 0 that rises and falls inside a blocked window shows that nothing is remembered. The same pin, held high while the block is clear, then shows that a level flag survives acknowledge. A single-clock pulse on external 1 in edge mode shows that the flag latches and is cleared by hardware. Timer pulses with the global enable off, or with only the source's own bit off, show the two kinds of gating. A pulse that arrives while the in-service flip-flop is set shows that the request waits for the return strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC        = 7;
  localparam int IDX_W        = 3;
  localparam int N_EXT        = 2;
  localparam int N_TMR        = 2;
  localparam int N_PER        = 3;
  localparam int PER_BASE     = 2 * N_EXT;
  localparam int VEC_W        = 16;
  localparam int VEC_BASE     = 3;
  localparam int VEC_STEP_LOG = 3;
  localparam int EN_W         = N_SRC + 1;
  localparam int GLOBAL_BIT   = N_SRC;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_EXT-1:0] ext_edge,
  input  logic [N_TMR-1:0] tmr_ovf,
  input  logic [N_PER-1:0] per_req,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] flags
);
  logic [N_EXT-1:0] pin_q;
  logic [N_SRC-1:0] flags_d;

  genvar j;
  generate
    for (j = 0; j < N_EXT; j++) begin : g_ext
      logic rise;
      assign rise = ext_pin[j] & ~pin_q[j];
      // edge mode: latch a rising edge, a new edge wins over the clear
      assign flags_d[2*j] = ext_edge[j] ? (rise | (flags[2*j] & ~clr[2*j]))
                                        : ext_pin[j];
    end
    for (j = 0; j < N_TMR; j++) begin : g_tmr
      assign flags_d[2*j+1] = tmr_ovf[j] | (flags[2*j+1] & ~clr[2*j+1]);
    end
    for (j = 0; j < N_PER; j++) begin : g_per
      assign flags_d[PER_BASE+j] = per_req[j];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '0;
      flags <= '0;
    end else begin
      pin_q <= ext_pin;
      flags <= flags_d;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N   = 7,
  parameter int IW  = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_poll_ctrl.sv
module irq_poll_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_EXT-1:0]  ext_edge,
  input  logic [N_TMR-1:0]  tmr_ovf,
  input  logic [N_PER-1:0]  per_req,
  input  logic              en_wr,
  input  logic [EN_W-1:0]   en_wdata,
  input  logic              blocked,
  input  logic              reti_stb,
  output logic              ack_o,
  output logic [IDX_W-1:0]  src_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [N_SRC-1:0]  flags_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [EN_W-1:0]  en_q,   en_d;
  logic [N_SRC-1:0] snap_q, snap_d;
  logic             act_q,  act_d;
  logic             ack_q,  ack_d;
  logic [IDX_W-1:0] src_q,  src_d;
  logic [N_SRC-1:0] clr;
  logic [N_SRC-1:0] hwclr_ok;
  logic             cand_any;
  logic [IDX_W-1:0] cand_idx;
  logic             hit;

  irq_flag_bank u_flags (
    .clk      (clk),
    .rst_n    (rst_q),
    .ext_pin  (ext_pin),
    .ext_edge (ext_edge),
    .tmr_ovf  (tmr_ovf),
    .per_req  (per_req),
    .clr      (clr),
    .flags    (flags_o)
  );

  irq_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req (snap_q & en_q[N_SRC-1:0]),
    .any (cand_any),
    .idx (cand_idx)
  );

  // which sources hardware may clear on acknowledge
  genvar k;
  generate
    for (k = 0; k < N_SRC; k++) begin : g_hw
      if (k < 2 * N_EXT && (k % 2) == 0) begin : g_e
        assign hwclr_ok[k] = ext_edge[k/2];
      end else if (k < 2 * N_TMR && (k % 2) == 1) begin : g_t
        assign hwclr_ok[k] = 1'b1;
      end else begin : g_p
        assign hwclr_ok[k] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    hit = cyc_stb & en_q[GLOBAL_BIT] & ~blocked & ~act_q & cand_any;
    clr = '0;
    if (hit) clr[cand_idx] = hwclr_ok[cand_idx];

    en_d   = en_wr ? en_wdata : en_q;
    snap_d = cyc_stb ? (flags_o & ~clr) : snap_q;
    if (hit)           act_d = 1'b1;
    else if (reti_stb) act_d = 1'b0;
    else               act_d = act_q;
    ack_d = hit;
    src_d = hit ? cand_idx : src_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      en_q   <= '0;
      snap_q <= '0;
      act_q  <= 1'b0;
      ack_q  <= 1'b0;
      src_q  <= '0;
    end else begin
      en_q   <= en_d;
      snap_q <= snap_d;
      act_q  <= act_d;
      ack_q  <= ack_d;
      src_q  <= src_d;
    end
  end

  assign ack_o = ack_q;
  assign src_o = src_q;
  assign vec_o = VEC_W'(VEC_BASE) + (VEC_W'(src_q) << VEC_STEP_LOG);

  // R5: the strobe lasts one cycle
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |=> !ack_o);
  // R5: vector shape
  p_vec_form_r5: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |-> (vec_o[2:0] == 3'd3 && vec_o[15:6] == '0));
  // R2: global enable gates acceptance
  p_global_r2: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |-> $past(en_q[GLOBAL_BIT]));
  // R6: no acknowledge while in service, and acknowledge marks it
  p_not_nested_r6: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |-> ($past(!act_q) && act_q));
  // R3/R7: acknowledge only after an unblocked strobe
  p_poll_r7: assert property (@(posedge clk) disable iff (!rst_q)
    ack_o |-> $past(cyc_stb && !blocked));
  // R8: an acknowledged timer flag is clear unless re-set meanwhile
  p_tmr_clr_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (ack_o && src_o == IDX_W'(1) && !$past(tmr_ovf[0])) |-> !flags_o[1]);
endmodule

// File: tb/sim_irq_poll_ctrl.sv
module sim_irq_poll_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_stb = 1'b0;
  logic [1:0]  ext_pin = '0, ext_edge = '0, tmr_ovf = '0;
  logic [2:0]  per_req = '0;
  logic        en_wr = 1'b0;
  logic [7:0]  en_wdata = '0;
  logic        blocked = 1'b0, reti_stb = 1'b0;
  logic        ack_o;
  logic [2:0]  src_o;
  logic [15:0] vec_o;
  logic [6:0]  flags_o;

  int n_chk = 0, n_fail = 0;
  int n_ack = 0;
  int last_vec = -1;
  string tag = "R1";
  bit run_stb = 1'b0;
  int stb_cnt = 0;

  always #10 clk = ~clk;

  irq_poll_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext_pin(ext_pin),
    .ext_edge(ext_edge), .tmr_ovf(tmr_ovf), .per_req(per_req),
    .en_wr(en_wr), .en_wdata(en_wdata), .blocked(blocked),
    .reti_stb(reti_stb), .ack_o(ack_o), .src_o(src_o), .vec_o(vec_o),
    .flags_o(flags_o)
  );

  // strobe every fourth clock
  always @(negedge clk) begin
    if (run_stb) begin
      stb_cnt = (stb_cnt + 1) % 4;
      cyc_stb <= (stb_cnt == 3);
    end else cyc_stb <= 1'b0;
  end

  // behavioural reference model
  int m_flag[7], m_snap[7], m_en[8], m_pin[2];
  int m_act, m_ack, m_src;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[i]) begin m_flag[i] = 0; m_snap[i] = 0; end
      foreach (m_en[i]) m_en[i] = 0;
      m_pin[0] = 0; m_pin[1] = 0;
      m_act = 0; m_ack = 0; m_src = 0;
    end else begin
      int best, win;
      int nf[7], clrm[7];
      best = -1;
      for (int i = 6; i >= 0; i--) if (m_snap[i] != 0 && m_en[i] != 0) best = i;
      win = (cyc_stb && m_en[7] != 0 && !blocked && m_act == 0 && best >= 0) ? 1 : 0;
      for (int i = 0; i < 7; i++) begin
        clrm[i] = 0;
        if (win != 0 && best == i)
          clrm[i] = (i == 1 || i == 3 || (i == 0 && ext_edge[0]) || (i == 2 && ext_edge[1])) ? 1 : 0;
      end
      for (int j = 0; j < 2; j++) begin
        if (ext_edge[j]) nf[2*j] = ((ext_pin[j] && m_pin[j] == 0) || (m_flag[2*j] != 0 && clrm[2*j] == 0)) ? 1 : 0;
        else             nf[2*j] = ext_pin[j] ? 1 : 0;
        nf[2*j+1] = (tmr_ovf[j] || (m_flag[2*j+1] != 0 && clrm[2*j+1] == 0)) ? 1 : 0;
      end
      for (int j = 0; j < 3; j++) nf[4+j] = per_req[j] ? 1 : 0;
      if (cyc_stb) for (int i = 0; i < 7; i++) m_snap[i] = (m_flag[i] != 0 && clrm[i] == 0) ? 1 : 0;
      for (int i = 0; i < 7; i++) m_flag[i] = nf[i];
      m_pin[0] = ext_pin[0]; m_pin[1] = ext_pin[1];
      if (en_wr) for (int i = 0; i < 8; i++) m_en[i] = en_wdata[i];
      if (win != 0) m_act = 1; else if (reti_stb) m_act = 0;
      m_ack = win;
      if (win != 0) m_src = best;
    end
  end

  // every-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      int mf;
      mf = 0;
      for (int i = 0; i < 7; i++) mf |= (m_flag[i] << i);
      n_chk++;
      if (ack_o !== m_ack[0] || flags_o !== mf[6:0] ||
          (m_ack != 0 && (src_o !== m_src[2:0] || vec_o !== 16'(3 + 8 * m_src)))) begin
        n_fail++;
        $display("FAIL %s model: ack=%0b src=%0d vec=%h flags=%b expected ack=%0d src=%0d vec=%h flags=%b",
                 tag, ack_o, src_o, vec_o, flags_o, m_ack, m_src, 16'(3 + 8 * m_src), mf[6:0]);
      end
      if (ack_o) begin n_ack++; last_vec = int'(vec_o); end
    end
  end

  task automatic check(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input int n);
    clocks(4 * n);
  endtask

  task automatic write_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v; clocks(1); en_wr = 1'b0;
  endtask

  task automatic pulse_reti();
    reti_stb = 1'b1; clocks(1); reti_stb = 1'b0;
  endtask

  task automatic pulse_tmr(input logic [1:0] m);
    tmr_ovf = m; clocks(1); tmr_ovf = '0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    clocks(3);
    rst_n = 1'b1;
    clocks(5);
    // R1: reset state
    tag = "R1";
    check("R1 ack", int'(ack_o), 0);
    check("R1 flags", int'(flags_o), 0);
    run_stb = 1'b1;
    strobes(2);

    // R2 global off, R11 timer flag sets and holds
    tag = "R2";
    write_en(8'h0F);
    pulse_tmr(2'b01);
    strobes(4);
    check("R2 no ack with global off", n_ack, 0);
    check("R11 timer0 flag held", int'(flags_o[1]), 1);
    // R2 own bit off: timer1 pending but disabled
    write_en(8'h80 | 8'h01);
    pulse_tmr(2'b10);
    strobes(4);
    check("R2 no ack with own bit off", n_ack, 0);
    check("R2 timer1 flag untouched", int'(flags_o[3]), 1);
    // enable timer0 only: acknowledged, vector 0x000B, flag cleared (R8)
    tag = "R5";
    write_en(8'h82);
    strobes(4);
    check("R5 one ack", n_ack, 1);
    check("R5 vector timer0", last_vec, 16'h000B);
    check("R8 timer0 flag cleared", int'(flags_o[1]), 0);
    pulse_reti();
    write_en(8'h8A);
    strobes(4);
    check("R3 timer1 served after enable", last_vec, 16'h001B);
    pulse_reti();
    strobes(2);

    // R4 priority and R9 peripheral flags held
    tag = "R4";
    write_en(8'hFF);
    base = n_ack;
    per_req = 3'b001;
    pulse_tmr(2'b11);
    strobes(4);
    check("R4 timer0 first", last_vec, 16'h000B);
    check("R6 single ack while in service", n_ack - base, 1);
    pulse_reti();
    strobes(4);
    check("R4 timer1 second", last_vec, 16'h001B);
    pulse_reti();
    strobes(4);
    tag = "R9";
    check("R9 uart served", last_vec, 16'h0023);
    check("R9 uart flag not cleared", int'(flags_o[4]), 1);
    pulse_reti();
    strobes(4);
    check("R9 uart served again", n_ack - base, 4);
    per_req = '0;
    strobes(3);
    pulse_reti();
    strobes(4);
    check("R9 nothing after release", n_ack - base, 4);

    // R7 blocked level request is dropped
    tag = "R7";
    write_en(8'h81);
    ext_edge = 2'b00;
    base = n_ack;
    blocked = 1'b1;
    ext_pin[0] = 1'b1;
    strobes(4);
    check("R7 no ack while blocked", n_ack - base, 0);
    ext_pin[0] = 1'b0;
    strobes(3);
    blocked = 1'b0;
    strobes(4);
    check("R7 dropped request not served", n_ack - base, 0);
    // R8 level flag follows pin, is not cleared by acknowledge
    tag = "R8";
    ext_pin[0] = 1'b1;
    strobes(4);
    check("R8 level ext0 served", last_vec, 16'h0003);
    check("R8 level flag kept", int'(flags_o[0]), 1);
    pulse_reti();
    strobes(4);
    check("R8 level ext0 served again", n_ack - base, 2);
    ext_pin[0] = 1'b0;
    strobes(3);
    pulse_reti();
    strobes(2);

    // R10 edge mode on external 1
    tag = "R10";
    write_en(8'h84);
    ext_edge = 2'b10;
    clocks(2);
    base = n_ack;
    ext_pin[1] = 1'b1; clocks(1); ext_pin[1] = 1'b0;
    clocks(1);
    check("R10 edge flag latched", int'(flags_o[2]), 1);
    strobes(4);
    check("R10 ext1 vector", last_vec, 16'h0013);
    check("R8 edge flag cleared", int'(flags_o[2]), 0);
    pulse_reti();
    strobes(2);

    // R6 request during service waits for return
    tag = "R6";
    write_en(8'h82);
    base = n_ack;
    pulse_tmr(2'b01);
    strobes(4);
    pulse_tmr(2'b01);
    strobes(4);
    check("R6 held off while in service", n_ack - base, 1);
    pulse_reti();
    strobes(4);
    check("R6 served after return", n_ack - base, 2);
    pulse_reti();
    strobes(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule